// File: doc/BRIEF.md
# PCI Master Cache Command Selector

This block sits between a bus-master transfer engine and the PCI bus interface. For each master transaction it picks the PCI memory command code. For a write, it also decides whether to cut the transfer into sub-bursts so that the whole-cache-line middle part can go out as Memory Write and Invalidate.

A request carries a transaction type, a direction, the low bits of the start address and a byte count. It is accepted on a valid/ready handshake. The block then presents one or more segments on a second valid/ready handshake. Each segment carries a command code, a segment byte length, an alignment-active flag and a last-segment marker.

The cache line size, the burst length fields and the command enable bits are taken when the request is accepted. They hold for every segment of that transaction. PCI signalling, the address and data phases and the data path belong to neighbouring logic.

Top module: `pci_cache_cmd_sel`

## Requirements
- R1: A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while no segment is pending. The first segment is valid on the next clock. A segment's fields hold steady while `seg_valid` is high and `seg_ready` is low.
- R2: Type codes 2 (non-prefetch script fetch), 3 (load/store move) and 4 (data flush) are never cache-handled. Every other type code is cache-handled when R3 and R4 allow it. A transaction that is not cache-handled gives exactly one segment. That segment carries Memory Read 0110 for a read or Memory Write 0111 for a write, `seg_align`=0, `seg_bytes` equal to the request byte count, and `seg_last`=1.
- R3: The burst length in Dwords is 2 shifted left by the 3-bit value {`cfg_burst_ext`, `cfg_burst_hi[1:0]`}, which gives 2 to 256. Cache handling requires this burst length to be at least `cfg_line_size`, which is given in Dwords. Equality qualifies.
- R4: A `cfg_line_size` of zero, or one that is not a power of two, turns off cache handling. A cache line is `cfg_line_size`×4 bytes.
- R5: A cache-handled read gives one segment with `seg_align`=0. Its preferred command is Memory Read Multiple 1100 when the byte count exceeds one line. Otherwise it is Memory Read Line 1110 when the start offset within the line plus the byte count reaches the line end. Otherwise it is Memory Read 0110.
- R6: A preferred Memory Read Multiple falls back to Memory Read Line when `en_read_mult`=0. A preferred Memory Read Line falls back to Memory Read when `en_read_line`=0. Both fallbacks apply in turn.
- R7: A cache-handled write is split into up to three segments, all with `seg_align`=1. The head segment is a Memory Write that runs from an unaligned start up to the next line boundary, or ends the transfer if the transfer ends first. The body segment covers all remaining whole lines. The tail segment is a Memory Write for the remainder. Empty pieces are omitted, and `seg_last`=1 marks the final segment.
- R8: The body segment uses Memory Write and Invalidate 1111 only when `en_wrinv_dev` and `en_wrinv_cfg` are both 1. Otherwise it uses Memory Write 0111 and the split of R7 is unchanged.
- R9: A read never has `seg_align`=1 and is always exactly one segment.
- R10: Configuration and enable inputs that change after acceptance have no effect on the segments of the accepted transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 3 | Transaction type code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr_lo | input | CLS_W+2 | Low start-address bits |
| req_bytes | input | CNT_W | Transfer byte count (non-zero) |
| cfg_burst_hi | input | 2 | Upper burst length field |
| cfg_burst_ext | input | 1 | Burst length extension bit |
| cfg_line_size | input | CLS_W | Cache line size in Dwords |
| en_read_line | input | 1 | Memory Read Line enable |
| en_read_mult | input | 1 | Memory Read Multiple enable |
| en_wrinv_dev | input | 1 | Write and Invalidate device enable |
| en_wrinv_cfg | input | 1 | Write and Invalidate configuration enable |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Segment taken by consumer |
| seg_cmd | output | 4 | PCI command code |
| seg_align | output | 1 | Write alignment active for this transaction |
| seg_bytes | output | CNT_W | Segment byte length |
| seg_last | output | 1 | Final segment of the transaction |

## Verification
The hardest situation to reach is a write that is still partway through its head, body and tail segments when its configuration is reconfigured to values that would change both the split and the command. The stimulus produces it in three steps. It starts a write at an unaligned offset with a length spanning several lines. It holds `seg_ready` low on a repeating pattern to keep the write in flight. While the write is in flight, it inverts every enable and zeroes the line size and burst fields. The segments must still match the configuration taken at acceptance. Fallback chains and the equality edge of the burst comparison are reached by choosing byte counts and offsets relative to the line end.

// File: rtl/cmdsel_pkg.sv
package cmdsel_pkg;

  typedef enum logic [3:0] {
    PCMD_MEM_RD  = 4'b0110,
    PCMD_MEM_WR  = 4'b0111,
    PCMD_RD_MULT = 4'b1100,
    PCMD_RD_LINE = 4'b1110,
    PCMD_WR_INV  = 4'b1111
  } pci_cmd_e;

  // Type codes that never take cache handling
  localparam logic [2:0] XK_FETCH_PLAIN = 3'd2;
  localparam logic [2:0] XK_LOAD_STORE  = 3'd3;
  localparam logic [2:0] XK_FLUSH       = 3'd4;

  function automatic logic kind_cacheable(logic [2:0] kind);
    return (kind != XK_FETCH_PLAIN) && (kind != XK_LOAD_STORE) && (kind != XK_FLUSH);
  endfunction

  // Burst length in Dwords: 2 << {ext, hi}
  function automatic logic [9:0] burst_dwords(logic [1:0] hi, logic ext);
    return 10'd2 << {ext, hi};
  endfunction

  // Walk down the read command preference while commands are disabled
  function automatic logic [3:0] read_fallback(logic [3:0] pref, logic line_ok, logic mult_ok);
    logic [3:0] c;
    c = pref;
    if (c == PCMD_RD_MULT && !mult_ok) c = PCMD_RD_LINE;
    if (c == PCMD_RD_LINE && !line_ok) c = PCMD_MEM_RD;
    return c;
  endfunction

endpackage

// File: rtl/cs_eligibility.sv
module cs_eligibility #(
  parameter int CLS_W = 8,
  parameter int LB_W  = CLS_W + 2
) (
  input  logic [2:0]       kind,
  input  logic [1:0]       burst_hi,
  input  logic             burst_ext,
  input  logic [CLS_W-1:0] line_size,
  output logic             eligible,
  output logic [LB_W-1:0]  line_bytes
);
  import cmdsel_pkg::*;

  logic [9:0] burst_dw;
  logic       size_pow2;
  logic       burst_covers;

  always_comb begin
    burst_dw     = burst_dwords(burst_hi, burst_ext);
    size_pow2    = (line_size != '0) && ((line_size & (line_size - CLS_W'(1))) == '0);
    burst_covers = 32'(burst_dw) >= 32'(line_size);
    eligible     = kind_cacheable(kind) && size_pow2 && burst_covers;
    line_bytes   = LB_W'({line_size, 2'b00});
  end
endmodule

// File: rtl/cs_read_pick.sv
module cs_read_pick #(
  parameter int CNT_W = 16,
  parameter int LB_W  = 10
) (
  input  logic [LB_W-1:0]  addr_lo,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [LB_W-1:0]  line_bytes,
  input  logic             en_line,
  input  logic             en_mult,
  output logic [3:0]       cmd
);
  import cmdsel_pkg::*;
  localparam int XW = ((CNT_W > LB_W) ? CNT_W : LB_W) + 1;

  logic [LB_W-1:0] offset;
  logic [XW-1:0]   cnt_x, line_x, reach_x;
  logic [3:0]      pref;

  always_comb begin
    offset  = addr_lo & (line_bytes - LB_W'(1));
    cnt_x   = XW'(nbytes);
    line_x  = XW'(line_bytes);
    reach_x = XW'(offset) + cnt_x;
    if (cnt_x > line_x)        pref = PCMD_RD_MULT;
    else if (reach_x >= line_x) pref = PCMD_RD_LINE;
    else                        pref = PCMD_MEM_RD;
    cmd = read_fallback(pref, en_line, en_mult);
  end
endmodule

// File: rtl/cs_write_seg.sv
module cs_write_seg #(
  parameter int CNT_W = 16,
  parameter int LB_W  = 10
) (
  input  logic [LB_W-1:0]  addr_lo,
  input  logic [CNT_W-1:0] remain,
  input  logic [LB_W-1:0]  line_bytes,
  input  logic             wrinv_ok,
  output logic [CNT_W-1:0] chunk,
  output logic [3:0]       cmd,
  output logic             last
);
  import cmdsel_pkg::*;
  localparam int XW = ((CNT_W > LB_W) ? CNT_W : LB_W) + 1;

  logic [XW-1:0] mask_x, off_x, room_x, rem_x, line_x, chunk_x;

  always_comb begin
    line_x = XW'(line_bytes);
    mask_x = line_x - XW'(1);
    off_x  = XW'(addr_lo) & mask_x;
    room_x = line_x - off_x;
    rem_x  = XW'(remain);
    if (off_x != '0) begin
      chunk_x = (rem_x < room_x) ? rem_x : room_x;
      cmd     = PCMD_MEM_WR;
    end else if (rem_x >= line_x) begin
      chunk_x = rem_x & ~mask_x;
      cmd     = wrinv_ok ? PCMD_WR_INV : PCMD_MEM_WR;
    end else begin
      chunk_x = rem_x;
      cmd     = PCMD_MEM_WR;
    end
    chunk = CNT_W'(chunk_x);
    last  = (chunk_x == rem_x);
  end
endmodule

// File: rtl/pci_cache_cmd_sel.sv
module pci_cache_cmd_sel #(
  parameter int CNT_W = 16,
  parameter int CLS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic             req_write,
  input  logic [CLS_W+1:0] req_addr_lo,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic [1:0]       cfg_burst_hi,
  input  logic             cfg_burst_ext,
  input  logic [CLS_W-1:0] cfg_line_size,
  input  logic             en_read_line,
  input  logic             en_read_mult,
  input  logic             en_wrinv_dev,
  input  logic             en_wrinv_cfg,
  output logic             seg_valid,
  input  logic             seg_ready,
  output logic [3:0]       seg_cmd,
  output logic             seg_align,
  output logic [CNT_W-1:0] seg_bytes,
  output logic             seg_last
);
  import cmdsel_pkg::*;
  localparam int LB_W = CLS_W + 2;

  // named internal events
  logic             accept, consume;
  logic             elig;
  logic [LB_W-1:0]  line_now;
  logic [3:0]       rd_cmd;

  // transaction state, captured at acceptance
  logic             busy_q, wr_q, split_q, wi_q;
  logic [LB_W-1:0]  off_q, line_q;
  logic [CNT_W-1:0] rem_q;
  logic [3:0]       rcmd_q;

  logic [CNT_W-1:0] ws_chunk;
  logic [3:0]       ws_cmd;
  logic             ws_last;

  cs_eligibility #(.CLS_W(CLS_W), .LB_W(LB_W)) u_elig (
    .kind(req_kind), .burst_hi(cfg_burst_hi), .burst_ext(cfg_burst_ext),
    .line_size(cfg_line_size), .eligible(elig), .line_bytes(line_now)
  );

  cs_read_pick #(.CNT_W(CNT_W), .LB_W(LB_W)) u_rd (
    .addr_lo(req_addr_lo), .nbytes(req_bytes), .line_bytes(line_now),
    .en_line(en_read_line), .en_mult(en_read_mult), .cmd(rd_cmd)
  );

  cs_write_seg #(.CNT_W(CNT_W), .LB_W(LB_W)) u_wr (
    .addr_lo(off_q), .remain(rem_q), .line_bytes(line_q), .wrinv_ok(wi_q),
    .chunk(ws_chunk), .cmd(ws_cmd), .last(ws_last)
  );

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign seg_valid = busy_q;
  assign consume   = seg_valid && seg_ready;
  assign seg_align = split_q;

  always_comb begin
    if (split_q) begin
      seg_cmd   = ws_cmd;
      seg_bytes = ws_chunk;
      seg_last  = ws_last;
    end else begin
      seg_cmd   = wr_q ? PCMD_MEM_WR : rcmd_q;
      seg_bytes = rem_q;
      seg_last  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      split_q <= 1'b0;
      wi_q    <= 1'b0;
      off_q   <= '0;
      line_q  <= '0;
      rem_q   <= '0;
      rcmd_q  <= PCMD_MEM_RD;
    end else if (accept) begin
      busy_q  <= 1'b1;
      wr_q    <= req_write;
      split_q <= req_write && elig;
      wi_q    <= en_wrinv_dev && en_wrinv_cfg;
      off_q   <= req_addr_lo;
      line_q  <= line_now;
      rem_q   <= req_bytes;
      rcmd_q  <= (!req_write && elig) ? rd_cmd : PCMD_MEM_RD;
    end else if (consume) begin
      if (seg_last) begin
        busy_q <= 1'b0;
      end else begin
        off_q <= off_q + LB_W'(ws_chunk);
        rem_q <= rem_q - ws_chunk;
      end
    end
  end
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int CNT_W = 16,
  parameter int LB_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             seg_valid,
  input logic             seg_ready,
  input logic [3:0]       seg_cmd,
  input logic             seg_align,
  input logic [CNT_W-1:0] seg_bytes,
  input logic             seg_last,
  input logic [LB_W-1:0]  line_q,
  input logic             wi_q
);
  logic [CNT_W-1:0] line_mask;
  assign line_mask = CNT_W'(line_q) - CNT_W'(1);

  // R1
  first_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> seg_valid);

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_cmd) && $stable(seg_bytes)
                                   && $stable(seg_last) && $stable(seg_align)));

  // R7
  split_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !seg_last) |=> (seg_valid && seg_align));

  // R7
  align_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_align) |-> (seg_cmd == 4'b0111 || seg_cmd == 4'b1111));

  // R8
  wrinv_whole_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_cmd == 4'b1111) |-> (wi_q && seg_bytes != '0 && (seg_bytes & line_mask) == '0));

  // R9
  single_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_align) |-> seg_last);
endmodule

bind pci_cache_cmd_sel cs_checker #(.CNT_W(CNT_W), .LB_W(LB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .seg_valid(seg_valid),
  .seg_ready(seg_ready), .seg_cmd(seg_cmd), .seg_align(seg_align),
  .seg_bytes(seg_bytes), .seg_last(seg_last), .line_q(line_q), .wi_q(wi_q)
);

// File: tb/tb_pci_cache_cmd_sel.sv
`timescale 1ns/1ps
module tb_pci_cache_cmd_sel;
  localparam int CNT_W = 16;
  localparam int CLS_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, seg_ready = 1'b0;
  logic [2:0] req_kind = '0;
  logic [CLS_W+1:0] req_addr_lo = '0;
  logic [CNT_W-1:0] req_bytes = '0;
  logic [1:0] cfg_burst_hi = '0;
  logic cfg_burst_ext = 1'b0;
  logic [CLS_W-1:0] cfg_line_size = '0;
  logic en_read_line = 1'b0, en_read_mult = 1'b0, en_wrinv_dev = 1'b0, en_wrinv_cfg = 1'b0;
  logic req_ready, seg_valid, seg_align, seg_last;
  logic [3:0] seg_cmd;
  logic [CNT_W-1:0] seg_bytes;

  pci_cache_cmd_sel #(.CNT_W(CNT_W), .CLS_W(CLS_W)) dut (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int c_hi, c_ext, c_cls;
  bit c_rl, c_rm, c_wd, c_wc;
  int q_cmd[$], q_len[$], q_aln[$], q_last[$];

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_pow2(int v);
    if (v <= 0) return 1'b0;
    while (v % 2 == 0) v = v / 2;
    return v == 1;
  endfunction

  function automatic void push(int c, int n, int a);
    q_cmd.push_back(c); q_len.push_back(n); q_aln.push_back(a); q_last.push_back(0);
  endfunction

  // behavioural reference: list of expected segments
  function automatic void build(int kind, bit wr, int addr, int cnt);
    int burst, line, off, pref, head, body, tail;
    bit ok;
    burst = 2 * (1 << (c_ext * 4 + c_hi));
    ok = !(kind == 2 || kind == 3 || kind == 4) && is_pow2(c_cls) && burst >= c_cls;
    line = c_cls * 4;
    if (!ok) push(wr ? 7 : 6, cnt, 0);
    else if (!wr) begin
      off = addr % line;
      if (cnt > line) pref = 12;
      else if (off + cnt >= line) pref = 14;
      else pref = 6;
      if (pref == 12 && !c_rm) pref = 14;
      if (pref == 14 && !c_rl) pref = 6;
      push(pref, cnt, 0);
    end else begin
      head = (line - addr % line) % line;
      if (head > cnt) head = cnt;
      body = ((cnt - head) / line) * line;
      tail = cnt - head - body;
      if (head > 0) push(7, head, 1);
      if (body > 0) push((c_wd && c_wc) ? 15 : 7, body, 1);
      if (tail > 0) push(7, tail, 1);
    end
    q_last[q_last.size() - 1] = 1;
  endfunction

  task automatic set_cfg(int hi, int ext, int cls, bit rl, bit rm, bit wd, bit wc);
    c_hi = hi; c_ext = ext; c_cls = cls; c_rl = rl; c_rm = rm; c_wd = wd; c_wc = wc;
  endtask

  task automatic run_txn(string tag, int kind, bit wr, int addr, int cnt, bit flip, int stall);
    int cyc;
    bit rdy;
    cfg_burst_hi = 2'(c_hi); cfg_burst_ext = 1'(c_ext); cfg_line_size = CLS_W'(c_cls);
    en_read_line = c_rl; en_read_mult = c_rm; en_wrinv_dev = c_wd; en_wrinv_cfg = c_wc;
    req_kind = 3'(kind); req_write = wr; req_addr_lo = (CLS_W+2)'(addr); req_bytes = CNT_W'(cnt);
    build(kind, wr, addr, cnt);
    chk("R1", "idle req_ready", int'(req_ready), 1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin  // R10: disturb configuration mid-transaction
      en_read_line = !c_rl; en_read_mult = !c_rm; en_wrinv_dev = !c_wd; en_wrinv_cfg = !c_wc;
      cfg_line_size = '0; cfg_burst_hi = '0; cfg_burst_ext = 1'b0;
    end
    cyc = 0;
    while (q_cmd.size() > 0 && cyc < 1000) begin
      chk("R1", "seg_valid", int'(seg_valid), 1);
      chk("R1", "busy req_ready", int'(req_ready), 0);
      chk(tag, "seg_cmd", int'(seg_cmd), q_cmd[0]);
      chk(tag, "seg_bytes", int'(seg_bytes), q_len[0]);
      chk(tag, "seg_align", int'(seg_align), q_aln[0]);
      chk(tag, "seg_last", int'(seg_last), q_last[0]);
      rdy = (stall == 0) || (cyc % stall != 0);
      seg_ready = rdy;
      @(posedge clk);
      if (rdy) begin
        void'(q_cmd.pop_front()); void'(q_len.pop_front());
        void'(q_aln.pop_front()); void'(q_last.pop_front());
      end
      @(negedge clk);
      seg_ready = 1'b0;
      cyc++;
    end
    chk("R1", "done seg_valid", int'(seg_valid), 0);
    chk("R1", "done req_ready", int'(req_ready), 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset seg_valid", int'(seg_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // line = 8 Dwords = 32 bytes, burst 16 Dwords
    set_cfg(3, 0, 8, 1, 1, 1, 1);
    run_txn("R5 multiple", 0, 0, 'h100, 100, 0, 0);
    run_txn("R5 line", 0, 0, 'h110, 16, 0, 0);
    run_txn("R5 plain", 1, 0, 'h104, 8, 0, 0);
    run_txn("R9 read stalled", 0, 0, 'h104, 300, 0, 3);
    set_cfg(3, 0, 8, 1, 0, 1, 1);
    run_txn("R6 mult to line", 0, 0, 'h100, 100, 0, 0);
    set_cfg(3, 0, 8, 0, 0, 1, 1);
    run_txn("R6 mult to read", 0, 0, 'h100, 100, 0, 0);
    set_cfg(3, 0, 8, 0, 1, 1, 1);
    run_txn("R6 line to read", 0, 0, 'h110, 16, 0, 0);
    run_txn("R6 mult kept", 0, 0, 'h100, 40, 0, 0);

    set_cfg(3, 0, 8, 1, 1, 1, 1);
    run_txn("R2 fetch read", 2, 0, 'h100, 100, 0, 0);
    run_txn("R2 loadstore write", 3, 1, 'h104, 100, 0, 0);
    run_txn("R2 flush write", 4, 1, 'h104, 100, 0, 2);
    run_txn("R2 kind7 eligible", 7, 1, 'h104, 100, 0, 0);

    set_cfg(0, 0, 8, 1, 1, 1, 1);
    run_txn("R3 burst short", 0, 0, 'h100, 100, 0, 0);
    set_cfg(2, 0, 8, 1, 1, 1, 1);
    run_txn("R3 burst equal", 0, 1, 'h108, 80, 0, 0);
    set_cfg(0, 1, 32, 1, 1, 1, 1);
    run_txn("R3 ext bit", 0, 1, 'h3f0, 300, 0, 0);

    set_cfg(3, 0, 0, 1, 1, 1, 1);
    run_txn("R4 zero size", 0, 0, 'h100, 100, 0, 0);
    set_cfg(3, 0, 12, 1, 1, 1, 1);
    run_txn("R4 non pow2", 0, 1, 'h104, 100, 0, 0);

    set_cfg(3, 0, 8, 1, 1, 1, 1);
    run_txn("R7 head body tail", 0, 1, 'h104, 100, 0, 0);
    run_txn("R7 aligned body", 1, 1, 'h200, 64, 0, 2);
    run_txn("R7 head only", 0, 1, 'h208, 10, 0, 0);
    run_txn("R7 tail only", 0, 1, 'h200, 5, 0, 0);
    set_cfg(3, 0, 8, 1, 1, 1, 0);
    run_txn("R8 cfg enable off", 0, 1, 'h104, 100, 0, 0);
    set_cfg(3, 0, 8, 0, 0, 0, 0);
    run_txn("R8 all disabled", 0, 1, 'h11c, 70, 0, 3);

    set_cfg(3, 0, 8, 1, 1, 1, 1);
    run_txn("R10 write reconfig", 0, 1, 'h104, 100, 1, 2);
    set_cfg(3, 0, 8, 0, 1, 0, 1);
    run_txn("R10 read reconfig", 0, 0, 'h110, 16, 1, 3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule